// File: doc/BRIEF.md
# Byte-Wide Flash Access Sequencer

This block lets a host read or write one byte of an external byte-wide parallel flash through two 32-bit registers. The first is a command register that holds the byte address, the access direction, a start bit and two boot status flags. The second is a data register that holds the byte being moved. When the host sets the start bit, the sequencer runs one fixed-length bus cycle on the flash pins. The cycle has three phases: address setup, then an enable-strobe window, then one release cycle. At the end of the cycle the sequencer clears the start bit. Software polls that bit to learn when the access has finished.

When reset is released, the sequencer reads flash bytes 0 and 1 on its own. It compares them against a two-byte signature set by a parameter, and the result appears as two separate flags: "boot check finished" and "signature matched". Host commands are locked out until the boot check is over, and also while any host access is running.

Top module: `flash_seq_ctrl`

## Requirements
- R1: Command register layout. Bits 18:0 are the byte address. Bit 24 is the direction (1 = read from flash, 0 = write to flash). Bit 25 is the start bit. Bit 26 is the signature-matched flag and bit 27 is the boot-finished flag; both are read-only. Bits 31:28 and 23:19 always read 0. Data register layout: bits 7:0 are the byte and bits 31:8 read 0. `bus_sel` = 0 selects the command register and `bus_sel` = 1 selects the data register.
- R2: After reset is released, the sequencer performs exactly two flash reads, first address 0 and then address 1. After that, the boot-finished flag is set and stays set until the next reset.
- R3: The signature-matched flag is set only if address 0 returned SIGNATURE[7:0] and address 1 returned SIGNATURE[15:8]. Otherwise it reads 0 once the boot-finished flag is set.
- R4: Writing a 1 to the start bit starts one access. The start bit reads 1 for exactly SETUP_CYC+STROBE_CYC+2 clock cycles after the write edge and then clears by itself.
- R5: Every access follows the same sequence. First, the address is driven with all strobes high for SETUP_CYC cycles. Next, `fl_ce_n` is held low for exactly STROBE_CYC cycles with the address stable. Finally, all strobes are high for one release cycle.
- R6: A read access pulses `fl_oe_n` low with `fl_we_n` high. The sequencer samples `fl_dq_in` at the clock edge that ends the strobe window and places that byte in data register bits 7:0.
- R7: A write access pulses `fl_we_n` low with `fl_oe_n` high. Throughout the access it drives data register bits 7:0 on `fl_dq_out`, with `fl_dq_oe` high.
- R8: Writes to either register are ignored while the boot check is unfinished or while an access is in progress. The ignored write starts no access and changes no register.
- R9: `fl_oe_n` and `fl_we_n` are never low together, and `fl_dq_oe` is never high while `fl_oe_n` is low. During reset all strobes are high and both registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_sel | input | 1 | Register select: 0 command, 1 data |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Contents of the selected register |
| fl_addr | output | 19 | Flash byte address |
| fl_dq_out | output | 8 | Byte driven to the flash |
| fl_dq_oe | output | 1 | Output enable for fl_dq_out |
| fl_dq_in | input | 8 | Byte returned by the flash |
| fl_ce_n | output | 1 | Chip enable, active low |
| fl_oe_n | output | 1 | Output enable strobe, active low |
| fl_we_n | output | 1 | Write enable strobe, active low |

## Verification
Some properties are checked on every cycle:
- the two strobes never overlap,
- the data pins are never driven during a read strobe, and are driven during a write strobe,
- the address holds steady under chip enable,
- each chip-enable window is exactly STROBE_CYC long,
- the start bit falls after the cycle completes,
- an ignored command write leaves the address unchanged,
- the signature flag never appears without the finished flag.

Only the bench scenarios can show the rest:
- that the boot reads address 0 before address 1,
- that a corrupted signature clears the match flag,
- that bytes written reach the right flash location and read back intact, including at the top address,
- that a data or command write issued during an access or during boot leaves no trace.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

  localparam int FL_ADDR_W   = 19;
  localparam int FL_DATA_W   = 8;
  localparam int BUS_W       = 32;

  localparam int CMD_DIR_BIT  = 24;
  localparam int CMD_GO_BIT   = 25;
  localparam int CMD_OK_BIT   = 26;
  localparam int CMD_FIN_BIT  = 27;

  typedef enum logic [1:0] {
    CYC_IDLE,
    CYC_SETUP,
    CYC_STROBE,
    CYC_RELEASE
  } cyc_state_e;

  typedef enum logic [2:0] {
    BOOT_RD0,
    BOOT_WAIT0,
    BOOT_RD1,
    BOOT_WAIT1,
    BOOT_FIN
  } boot_state_e;

endpackage

// File: rtl/flash_cycle_engine.sv
module flash_cycle_engine
  import flash_seq_pkg::*;
#(
  parameter int SETUP_CYC  = 2,
  parameter int STROBE_CYC = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req,
  input  logic                 req_read,
  input  logic [FL_ADDR_W-1:0] req_addr,
  input  logic [FL_DATA_W-1:0] req_wdata,
  output logic                 done,
  output logic [FL_DATA_W-1:0] rd_byte,
  output logic [FL_ADDR_W-1:0] fl_addr,
  output logic [FL_DATA_W-1:0] fl_dq_out,
  output logic                 fl_dq_oe,
  input  logic [FL_DATA_W-1:0] fl_dq_in,
  output logic                 fl_ce_n,
  output logic                 fl_oe_n,
  output logic                 fl_we_n
);

  localparam int MAX_PH = (SETUP_CYC > STROBE_CYC) ? SETUP_CYC : STROBE_CYC;
  localparam int CNT_W  = $clog2(MAX_PH + 1);
  localparam logic [CNT_W-1:0] SETUP_LAST  = CNT_W'(SETUP_CYC - 1);
  localparam logic [CNT_W-1:0] STROBE_LAST = CNT_W'(STROBE_CYC - 1);
  localparam int RUN_W = $clog2(STROBE_CYC + 2);

  cyc_state_e           state_q, state_d;
  logic [CNT_W-1:0]     cnt_q, cnt_d;
  logic [FL_ADDR_W-1:0] addr_q, addr_d;
  logic [FL_DATA_W-1:0] wdata_q, wdata_d;
  logic [FL_DATA_W-1:0] rbyte_q, rbyte_d;
  logic                 read_q, read_d;
  logic                 strobe_on;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    addr_d  = addr_q;
    wdata_d = wdata_q;
    read_d  = read_q;
    rbyte_d = rbyte_q;
    case (state_q)
      CYC_IDLE: begin
        if (req) begin
          state_d = CYC_SETUP;
          cnt_d   = '0;
          addr_d  = req_addr;
          wdata_d = req_wdata;
          read_d  = req_read;
        end
      end
      CYC_SETUP: begin
        if (cnt_q == SETUP_LAST) begin
          state_d = CYC_STROBE;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      CYC_STROBE: begin
        if (cnt_q == STROBE_LAST) begin
          state_d = CYC_RELEASE;
          cnt_d   = '0;
          if (read_q) rbyte_d = fl_dq_in;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: state_d = CYC_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CYC_IDLE;
      cnt_q   <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      read_q  <= 1'b0;
      rbyte_q <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      addr_q  <= addr_d;
      wdata_q <= wdata_d;
      read_q  <= read_d;
      rbyte_q <= rbyte_d;
    end
  end

  assign strobe_on = (state_q == CYC_STROBE);
  assign fl_addr   = addr_q;
  assign fl_dq_out = wdata_q;
  assign fl_dq_oe  = !read_q && (state_q != CYC_IDLE);
  assign fl_ce_n   = !strobe_on;
  assign fl_oe_n   = !(strobe_on && read_q);
  assign fl_we_n   = !(strobe_on && !read_q);
  assign done      = (state_q == CYC_RELEASE);
  assign rd_byte   = rbyte_q;

  // checker-only: length of the current chip-enable run
  logic [RUN_W-1:0] strobe_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        strobe_run <= '0;
    else if (!fl_ce_n) strobe_run <= strobe_run + 1'b1;
    else               strobe_run <= '0;
  end

  AST_STROBE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n) !(!fl_oe_n && !fl_we_n)); // R9
  AST_NO_DRIVE_ON_READ: assert property (@(posedge clk) disable iff (!rst_n) !fl_oe_n |-> !fl_dq_oe); // R9
  AST_WRITE_DRIVES:     assert property (@(posedge clk) disable iff (!rst_n) !fl_we_n |-> fl_dq_oe); // R7
  AST_STROBE_WIDTH:     assert property (@(posedge clk) disable iff (!rst_n) $rose(fl_ce_n) |-> (strobe_run == RUN_W'(STROBE_CYC))); // R5
  AST_ADDR_HELD:        assert property (@(posedge clk) disable iff (!rst_n) !fl_ce_n |-> $stable(fl_addr)); // R5
  AST_RELEASE_AFTER:    assert property (@(posedge clk) disable iff (!rst_n) done |-> $past(!fl_ce_n)); // R5

endmodule

// File: rtl/flash_ctrl_regs.sv
module flash_ctrl_regs
  import flash_seq_pkg::*;
#(
  parameter logic [15:0] SIGNATURE = 16'hA55A
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_wr,
  input  logic                 bus_sel,
  input  logic [BUS_W-1:0]     bus_wdata,
  output logic [BUS_W-1:0]     bus_rdata,
  input  logic                 eng_done,
  input  logic [FL_DATA_W-1:0] eng_rd_byte,
  output logic                 req,
  output logic                 req_read,
  output logic [FL_ADDR_W-1:0] req_addr,
  output logic [FL_DATA_W-1:0] req_wdata
);

  localparam logic [FL_DATA_W-1:0] SIG_LO = SIGNATURE[7:0];
  localparam logic [FL_DATA_W-1:0] SIG_HI = SIGNATURE[15:8];
  localparam int GAP_LO = FL_ADDR_W;
  localparam int GAP_HI = CMD_DIR_BIT - 1;

  boot_state_e          boot_q, boot_d;
  logic                 fin_q, fin_d;
  logic                 ok_q, ok_d;
  logic                 lo_match_q, lo_match_d;
  logic [FL_ADDR_W-1:0] addr_q, addr_d;
  logic                 dir_q, dir_d;
  logic                 go_bit_q, go_bit_d;
  logic                 kick_q, kick_d;
  logic [FL_DATA_W-1:0] data_q, data_d;
  logic                 boot_issue, host_free, cmd_wr, data_wr, host_end;

  // boot signature check
  always_comb begin
    boot_d     = boot_q;
    fin_d      = fin_q;
    ok_d       = ok_q;
    lo_match_d = lo_match_q;
    case (boot_q)
      BOOT_RD0:   boot_d = BOOT_WAIT0;
      BOOT_WAIT0: begin
        if (eng_done) begin
          lo_match_d = (eng_rd_byte == SIG_LO);
          boot_d     = BOOT_RD1;
        end
      end
      BOOT_RD1:   boot_d = BOOT_WAIT1;
      BOOT_WAIT1: begin
        if (eng_done) begin
          ok_d   = lo_match_q && (eng_rd_byte == SIG_HI);
          fin_d  = 1'b1;
          boot_d = BOOT_FIN;
        end
      end
      default:    boot_d = BOOT_FIN;
    endcase
  end

  assign boot_issue = (boot_q == BOOT_RD0) || (boot_q == BOOT_RD1);

  // host command path
  assign host_free = fin_q && !go_bit_q;
  assign cmd_wr    = bus_wr && !bus_sel && host_free;
  assign data_wr   = bus_wr &&  bus_sel && host_free;
  assign host_end  = eng_done && go_bit_q;

  always_comb begin
    addr_d   = addr_q;
    dir_d    = dir_q;
    go_bit_d = go_bit_q;
    data_d   = data_q;
    kick_d   = 1'b0;
    if (cmd_wr) begin
      addr_d   = bus_wdata[FL_ADDR_W-1:0];
      dir_d    = bus_wdata[CMD_DIR_BIT];
      go_bit_d = bus_wdata[CMD_GO_BIT];
      kick_d   = bus_wdata[CMD_GO_BIT];
    end else if (host_end) begin
      go_bit_d = 1'b0;
    end
    if (data_wr) begin
      data_d = bus_wdata[FL_DATA_W-1:0];
    end else if (host_end && dir_q) begin
      data_d = eng_rd_byte;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      boot_q     <= BOOT_RD0;
      fin_q      <= 1'b0;
      ok_q       <= 1'b0;
      lo_match_q <= 1'b0;
      addr_q     <= '0;
      dir_q      <= 1'b0;
      go_bit_q   <= 1'b0;
      kick_q     <= 1'b0;
      data_q     <= '0;
    end else begin
      boot_q     <= boot_d;
      fin_q      <= fin_d;
      ok_q       <= ok_d;
      lo_match_q <= lo_match_d;
      addr_q     <= addr_d;
      dir_q      <= dir_d;
      go_bit_q   <= go_bit_d;
      kick_q     <= kick_d;
      data_q     <= data_d;
    end
  end

  assign req       = boot_issue || kick_q;
  assign req_read  = boot_issue || dir_q;
  assign req_addr  = boot_issue ? FL_ADDR_W'(boot_q == BOOT_RD1) : addr_q;
  assign req_wdata = data_q;

  always_comb begin
    if (bus_sel) begin
      bus_rdata = {{(BUS_W-FL_DATA_W){1'b0}}, data_q};
    end else begin
      bus_rdata = {{(BUS_W-CMD_FIN_BIT-1){1'b0}}, fin_q, ok_q, go_bit_q, dir_q,
                   {(GAP_HI-GAP_LO+1){1'b0}}, addr_q};
    end
  end

  logic unused_wbits;
  assign unused_wbits = ^{bus_wdata[BUS_W-1:CMD_OK_BIT], bus_wdata[GAP_HI:GAP_LO]};

  AST_CMD_LOCKED:    assert property (@(posedge clk) disable iff (!rst_n) (go_bit_q && bus_wr && !bus_sel) |=> ($stable(addr_q) && $stable(dir_q))); // R8
  AST_BOOT_LOCKED:   assert property (@(posedge clk) disable iff (!rst_n) (!fin_q && bus_wr && !bus_sel) |=> !go_bit_q); // R8
  AST_START_CLEARS:  assert property (@(posedge clk) disable iff (!rst_n) (eng_done && go_bit_q) |=> !go_bit_q); // R4
  AST_OK_NEEDS_FIN:  assert property (@(posedge clk) disable iff (!rst_n) ok_q |-> fin_q); // R3
  AST_FIN_STICKY:    assert property (@(posedge clk) disable iff (!rst_n) fin_q |=> fin_q); // R2

endmodule

// File: rtl/flash_seq_ctrl.sv
module flash_seq_ctrl
  import flash_seq_pkg::*;
#(
  parameter int          SETUP_CYC  = 2,
  parameter int          STROBE_CYC = 4,
  parameter logic [15:0] SIGNATURE  = 16'hA55A
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_wr,
  input  logic                 bus_sel,
  input  logic [BUS_W-1:0]     bus_wdata,
  output logic [BUS_W-1:0]     bus_rdata,
  output logic [FL_ADDR_W-1:0] fl_addr,
  output logic [FL_DATA_W-1:0] fl_dq_out,
  output logic                 fl_dq_oe,
  input  logic [FL_DATA_W-1:0] fl_dq_in,
  output logic                 fl_ce_n,
  output logic                 fl_oe_n,
  output logic                 fl_we_n
);

  // reset asserted asynchronously, released on the clock
  logic [1:0] rst_pipe_q;
  logic       rst_core_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_core_n = rst_pipe_q[1];

  logic                 req, req_read, eng_done;
  logic [FL_ADDR_W-1:0] req_addr;
  logic [FL_DATA_W-1:0] req_wdata, eng_rd_byte;

  flash_ctrl_regs #(
    .SIGNATURE (SIGNATURE)
  ) i_regs (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .bus_wr      (bus_wr),
    .bus_sel     (bus_sel),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .eng_done    (eng_done),
    .eng_rd_byte (eng_rd_byte),
    .req         (req),
    .req_read    (req_read),
    .req_addr    (req_addr),
    .req_wdata   (req_wdata)
  );

  flash_cycle_engine #(
    .SETUP_CYC  (SETUP_CYC),
    .STROBE_CYC (STROBE_CYC)
  ) i_engine (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .req       (req),
    .req_read  (req_read),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .done      (eng_done),
    .rd_byte   (eng_rd_byte),
    .fl_addr   (fl_addr),
    .fl_dq_out (fl_dq_out),
    .fl_dq_oe  (fl_dq_oe),
    .fl_dq_in  (fl_dq_in),
    .fl_ce_n   (fl_ce_n),
    .fl_oe_n   (fl_oe_n),
    .fl_we_n   (fl_we_n)
  );

endmodule

// File: tb/test_flash_seq_ctrl.sv
module test_flash_seq_ctrl;

  localparam int SETUP_CYC  = 2;
  localparam int STROBE_CYC = 4;
  localparam logic [15:0] SIG = 16'hA55A;
  localparam int BUSY_CYC = SETUP_CYC + STROBE_CYC + 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_sel = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [18:0] fl_addr;
  logic [7:0]  fl_dq_out, fl_dq_in;
  logic        fl_dq_oe, fl_ce_n, fl_oe_n, fl_we_n;

  always #5 clk = ~clk;

  flash_seq_ctrl #(
    .SETUP_CYC(SETUP_CYC), .STROBE_CYC(STROBE_CYC), .SIGNATURE(SIG)
  ) i_flash_seq_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_sel(bus_sel),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .fl_addr(fl_addr),
    .fl_dq_out(fl_dq_out), .fl_dq_oe(fl_dq_oe), .fl_dq_in(fl_dq_in),
    .fl_ce_n(fl_ce_n), .fl_oe_n(fl_oe_n), .fl_we_n(fl_we_n)
  );

  // behavioural flash: 512 bytes, indexed by the low address bits
  logic [7:0]  mem [0:511];
  logic [18:0] last_waddr;
  assign fl_dq_in = (!fl_ce_n && !fl_oe_n) ? mem[fl_addr[8:0]] : 8'h00;
  always @(posedge clk) begin
    if (!fl_ce_n && !fl_we_n) begin
      mem[fl_addr[8:0]] <= fl_dq_out;
      last_waddr        <= fl_addr;
    end
  end

  // pin monitor
  int          n_tests = 0, n_fail = 0;
  int          ce_lows = 0, n_reads = 0, pin_errs = 0;
  logic [18:0] rd_log [0:3];
  logic        oe_was_low = 1'b0;
  always @(negedge clk) begin
    if (!fl_ce_n) ce_lows++;
    if (!fl_oe_n && !oe_was_low) begin
      if (n_reads < 4) rd_log[n_reads] = fl_addr;
      n_reads++;
    end
    oe_was_low = !fl_oe_n;
    if (rst_n && ((!fl_oe_n && !fl_we_n) || (!fl_oe_n && fl_dq_oe) || (!fl_we_n && !fl_dq_oe)))
      pin_errs++;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  task automatic reg_wr(input logic sel, input logic [31:0] d);
    @(negedge clk);
    bus_sel = sel; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic reg_rd(input logic sel, output logic [31:0] d);
    bus_sel = sel;
    #1 d = bus_rdata;
  endtask

  task automatic wait_start_clear(output int dur);
    logic [31:0] v;
    dur = 0;
    for (int i = 0; i < 200; i++) begin
      reg_rd(1'b0, v);
      if (!v[25]) break;
      dur++;
      @(negedge clk);
    end
  endtask

  task automatic do_reset();
    logic [31:0] v;
    @(negedge clk);
    rst_n = 1'b0; bus_wr = 1'b0;
    repeat (3) @(negedge clk);
    n_reads = 0;
    reg_rd(1'b0, v);
    chk("R9 reset cmd", v, 32'h0);
    reg_rd(1'b1, v);
    chk("R9 reset data", v, 32'h0);
    chk("R9 reset strobes", {29'b0, fl_ce_n, fl_oe_n, fl_we_n}, 32'h7);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wait_boot();
    logic [31:0] v;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      reg_rd(1'b0, v);
      if (v[27]) break;
    end
  endtask

  typedef struct packed {
    logic        rd;
    logic [18:0] a;
    logic [7:0]  d;
  } vec_t;

  localparam vec_t VEC [0:8] = '{
    '{1'b0, 19'h00010, 8'h3C},
    '{1'b0, 19'h7FFFF, 8'hC3},
    '{1'b0, 19'h40020, 8'h00},
    '{1'b0, 19'h00002, 8'hFF},
    '{1'b1, 19'h00010, 8'h3C},
    '{1'b1, 19'h7FFFF, 8'hC3},
    '{1'b1, 19'h40020, 8'h00},
    '{1'b1, 19'h00002, 8'hFF},
    '{1'b1, 19'h00000, 8'h5A}
  };

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    int dur;
    for (int i = 0; i < 512; i++) mem[i] = 8'h00;
    mem[0] = SIG[7:0];
    mem[1] = 8'h00;

    // bad signature
    do_reset();
    wait_boot();
    reg_rd(1'b0, v);
    chk("R3 bad signature status", v, 32'h0800_0000);

    // good signature, host writes during boot ignored
    mem[1] = SIG[15:8];
    do_reset();
    reg_wr(1'b0, 32'h0300_0123);
    reg_wr(1'b1, 32'h0000_0077);
    wait_boot();
    repeat (12) @(negedge clk);
    reg_rd(1'b0, v);
    chk("R3 R8 boot status, cmd untouched", v, 32'h0C00_0000);
    reg_rd(1'b1, v);
    chk("R8 data untouched during boot", v, 32'h0);
    chk("R2 boot read count", n_reads, 2);
    chk("R2 first boot address", {13'b0, rd_log[0]}, 32'h0);
    chk("R2 second boot address", {13'b0, rd_log[1]}, 32'h1);

    // vector table
    foreach (VEC[k]) begin
      if (!VEC[k].rd) reg_wr(1'b1, {24'h0, VEC[k].d});
      ce_lows = 0;
      reg_wr(1'b0, 32'h0200_0000 | (32'(VEC[k].rd) << 24) | {13'b0, VEC[k].a});
      wait_start_clear(dur);
      chk("R4 start bit duration", dur, BUSY_CYC);
      chk("R5 strobe width", ce_lows, STROBE_CYC);
      if (VEC[k].rd) begin
        reg_rd(1'b1, v);
        chk("R6 read byte", v, {24'h0, VEC[k].d});
      end else begin
        chk("R7 flash byte written", {24'h0, mem[VEC[k].a[8:0]]}, {24'h0, VEC[k].d});
        chk("R7 write address", {13'b0, last_waddr}, {13'b0, VEC[k].a});
      end
    end

    // writes during a running access are ignored
    reg_wr(1'b1, 32'h0000_0011);
    reg_wr(1'b0, 32'h0200_0100);
    reg_wr(1'b1, 32'h0000_00EE);
    reg_wr(1'b0, 32'h0300_0155);
    wait_start_clear(dur);
    repeat (12) @(negedge clk);
    chk("R8 original write landed", {24'h0, mem[9'h100]}, 32'h11);
    chk("R8 no second access", {24'h0, mem[9'h155]}, 32'h00);
    reg_rd(1'b0, v);
    chk("R8 cmd kept", v, 32'h0C00_0100);
    reg_rd(1'b1, v);
    chk("R8 data kept", v, 32'h11);

    // reserved bits and read-only flags
    ce_lows = 0;
    reg_wr(1'b0, 32'hFDFF_FFFF);
    reg_rd(1'b0, v);
    chk("R1 cmd layout", v, 32'h0D07_FFFF);
    reg_wr(1'b1, 32'hFFFF_FF81);
    reg_rd(1'b1, v);
    chk("R1 data layout", v, 32'h0000_0081);
    chk("R4 no access without start", ce_lows, 0);

    chk("R9 pin exclusivity", pin_errs, 0);
    finish_run();
  end

endmodule